// File: doc/BRIEF.md
# Asynchronous Serial Port with Ninth-Bit Address Filtering

This block is a full-duplex asynchronous serial port with a transmitter and a receiver. A two-bit mode field selects one of two frame formats. The first is a ten-bit frame with eight data bits, paced by an external oversampling tick. The second is an eleven-bit frame with a ninth bit that software controls, paced by a divider on the core clock. A rate-doubling input halves the bit period in the second format. The other two mode codes, including the shift-register code, leave both directions idle.

Software writes a byte to start a transmission and reads the received byte, the received ninth bit and two event flags. It clears each flag by pulsing a clear input. The receiver accepts a frame only if the previous byte has been taken, which means the receive flag is clear. A single control bit then adds a check that depends on the mode. In the eight-bit format the stop bit must be high. In the nine-bit format only frames with the ninth bit high are accepted, so a node can listen for address frames alone. Software clears the control bit once its address matches, which lets data frames through.

Top module: `addr_filter_uart`

## Requirements
- R1: After reset `txd` is 1, and `tx_flag`, `rx_flag`, `rx_bit9` and `rx_data` are all 0.
- R2: With `mode_sel` = 2'b01, a write sends a start bit (0), then the eight data bits least significant first, then a stop bit (1). Each bit lasts 16 pulses of `baud_tick`.
- R3: With `mode_sel` = 2'b10, a write sends a start bit, the eight data bits least significant first, `tx_bit9`, and then a stop bit. Each bit lasts FIX_DIV clocks, or FIX_DIV/2 clocks when `dbl_rate` is 1.
- R4: `tx_flag` rises when the stop bit appears on `txd` and not earlier. A write while a frame is being sent has no effect. A write while `mode_sel` is 2'b00 or 2'b11 has no effect, and `txd` stays 1.
- R5: In mode 2'b01, an accepted frame loads its data into `rx_data`, loads its stop bit into `rx_bit9`, and sets `rx_flag`.
- R6: A frame that ends while `rx_flag` is 1 is discarded, and `rx_data` keeps its value.
- R7: In mode 2'b01 with `chk_en` = 1, a frame whose stop bit is 0 is discarded and `rx_flag` stays 0. With `chk_en` = 0 the same frame is accepted, and `rx_bit9` reads 0.
- R8: In mode 2'b10 the received ninth bit goes to `rx_bit9`. With `chk_en` = 1 only frames whose ninth bit is 1 are accepted. Frames whose ninth bit is 0 leave `rx_flag` at 0.
- R9: Each bit is sampled on oversampling ticks 7, 8 and 9 of the 16 ticks in a bit, and the majority of the three samples is taken. A falling edge whose start bit reads high by majority is dropped.
- R10: While `rx_en` is 0, or `mode_sel` is 2'b00 or 2'b11, no frame is received.
- R11: In mode 2'b10 with `dbl_rate` = 1, the receiver decodes frames at half the bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Frame mode: 01 eight-bit external rate, 10 nine-bit fixed rate |
| rx_en | input | 1 | Receiver enable |
| chk_en | input | 1 | Stop-bit check (01) or address filter (10) |
| dbl_rate | input | 1 | Halves the fixed-rate bit period |
| baud_tick | input | 1 | Oversampling tick for mode 01, 16 per bit |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit sent in mode 10 |
| tx_flag_clr | input | 1 | Clears `tx_flag` |
| rx_flag_clr | input | 1 | Clears `rx_flag` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_flag | output | 1 | Stop bit reached the line |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the last accepted frame |
| rx_flag | output | 1 | An accepted frame is waiting |

## Verification
The bench builds the block with its default parameters: DATA_W = 8, OVS = 16 and FIX_DIV = 64. It drives `baud_tick` on every third clock. As a result an eight-bit frame bit lasts 48 clocks, a nine-bit frame bit lasts 64 clocks, and a doubled-rate bit lasts 32 clocks. These short periods keep every rate, both settings of the check bit, the discard of a frame held off by the receive flag, and a rejected start glitch within a few thousand cycles each.

// File: rtl/addr_filter_uart_pkg.sv
// Shared mode encoding for the asynchronous serial port.
// Assumes the mode field is stable while a frame is in flight.
package addr_filter_uart_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_VAR8  = 2'b01,
        MODE_FIX9  = 2'b10,
        MODE_RSVD  = 2'b11
    } uart_mode_e;
endpackage

// File: rtl/afu_tick_gen.sv
// Produces the oversampling tick: the external tick in eight-bit mode,
// or a core-clock divider in nine-bit mode (FIX_DIV/OVS clocks per tick,
// half that when doubled). Assumes FIX_DIV is a multiple of 2*OVS.
module afu_tick_gen
    import addr_filter_uart_pkg::*;
#(
    parameter int OVS     = 16,
    parameter int FIX_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       dbl_i,
    input  logic       ext_tick_i,
    output logic       tick_o
);
    localparam int SLOW = FIX_DIV / OVS;
    localparam int FAST = SLOW / 2;
    localparam int CW   = (SLOW > 1) ? $clog2(SLOW) : 1;

    logic [CW-1:0] div_q;
    logic [CW-1:0] limit;
    logic          fix_tick;

    // Pick the divider terminal count for the selected rate.
    always_comb begin
        limit    = dbl_i ? CW'(FAST - 1) : CW'(SLOW - 1);
        fix_tick = (mode_i == MODE_FIX9) && (div_q >= limit);
        tick_o   = ((mode_i == MODE_VAR8) && ext_tick_i) || fix_tick;
    end

    // Free-running divider, held at zero outside nine-bit mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    div_q <= '0;
        else if (mode_i != MODE_FIX9 || div_q >= limit) div_q <= '0;
        else                                           div_q <= div_q + 1'b1;
    end

    // At the undoubled fixed rate two ticks never come back to back.
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && mode_i == MODE_FIX9 && !dbl_i)
        |=> !(tick_o && mode_i == MODE_FIX9 && !dbl_i));
endmodule

// File: rtl/afu_tx.sv
// Transmit shifter: loads start, data, ninth/stop and stop bits in one
// register and shifts them out LSB first, each bit lasting OVS ticks.
// Writes while busy or in an inactive mode are dropped.
module afu_tx
    import addr_filter_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              bit9_i,
    input  logic              flag_clr_i,
    output logic              txd_o,
    output logic              flag_o
);
    localparam int FR8    = DATA_W + 2;
    localparam int FR9    = DATA_W + 3;
    localparam int LEFT_W = $clog2(FR9 + 1);
    localparam int OVS_W  = $clog2(OVS);
    localparam logic [OVS_W-1:0] LAST_TICK = OVS_W'(OVS - 1);

    logic [FR9-1:0]    shreg;
    logic [LEFT_W-1:0] left;
    logic [OVS_W-1:0]  cnt;
    logic              busy;
    logic              load;
    logic              bit_end;

    // Decode a write that may start a frame and the end of each bit.
    always_comb begin
        load    = wr_i && !busy && (mode_i == MODE_VAR8 || mode_i == MODE_FIX9);
        bit_end = busy && tick_i && (cnt == LAST_TICK);
    end

    assign txd_o = shreg[0];

    // Frame shifter: load on write, shift one bit per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= {1'b1, (mode_i == MODE_FIX9) ? bit9_i : 1'b1, data_i, 1'b0};
            left  <= (mode_i == MODE_FIX9) ? LEFT_W'(FR9) : LEFT_W'(FR8);
            cnt   <= '0;
            busy  <= 1'b1;
        end else if (busy && tick_i) begin
            cnt <= cnt + 1'b1;
            if (bit_end) begin
                if (left == LEFT_W'(1)) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[FR9-1:1]};
                    left  <= left - 1'b1;
                end
            end
        end
    end

    // Transmit flag: set as the stop bit is shifted onto the line.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   flag_o <= 1'b0;
        else if (bit_end && left == LEFT_W'(2))        flag_o <= 1'b1;
        else if (flag_clr_i)                          flag_o <= 1'b0;
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd_o);
    assert_flag_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> (txd_o && busy));
endmodule

// File: rtl/afu_rx.sv
// Receiver: detects a falling edge, votes three mid-bit samples per bit,
// drops false starts, and at the final bit applies the acceptance rules
// (flag clear, plus stop-bit check or ninth-bit filter) before updating
// the buffer. Assumes rxd_i is already synchronised.
module afu_rx
    import addr_filter_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              en_i,
    input  logic              chk_i,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              flag_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              flag_o
);
    localparam int OVS_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam logic [OVS_W-1:0] SAMP_A = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] SAMP_B = OVS_W'(OVS / 2);
    localparam logic [OVS_W-1:0] SAMP_C = OVS_W'(OVS / 2 + 1);
    localparam logic [IDX_W-1:0] IDX_LAST_DATA = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] IDX_EXTRA     = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_STOP9     = IDX_W'(DATA_W + 2);

    logic              active;
    logic              nine;
    logic [OVS_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic              s_a, s_b;
    logic              rxd_prev;
    logic              b9_q;
    logic [DATA_W-1:0] shreg;
    logic              vote, decide, is_last, start_edge, frame_nine, accept;

    // Majority vote, final-bit decode and acceptance rules.
    always_comb begin
        vote       = (s_a & s_b) | (s_a & rxd_i) | (s_b & rxd_i);
        decide     = active && tick_i && (cnt == SAMP_C);
        is_last    = nine ? (idx == IDX_STOP9) : (idx == IDX_EXTRA);
        frame_nine = nine ? b9_q : vote;
        accept     = decide && is_last && !flag_o && (!chk_i || frame_nine);
        start_edge = !active && en_i && rxd_prev && !rxd_i
                     && (mode_i == MODE_VAR8 || mode_i == MODE_FIX9);
    end

    // Previous line level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_prev <= 1'b1;
        else        rxd_prev <= rxd_i;
    end

    // Bit sequencer: tick counting, sampling and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            nine   <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            s_a    <= 1'b1;
            s_b    <= 1'b1;
            b9_q   <= 1'b0;
            shreg  <= '0;
        end else if (!active) begin
            if (start_edge) begin
                active <= 1'b1;
                cnt    <= '0;
                idx    <= '0;
                nine   <= (mode_i == MODE_FIX9);
            end
        end else if (tick_i) begin
            cnt <= cnt + 1'b1;
            if (cnt == SAMP_A) s_a <= rxd_i;
            if (cnt == SAMP_B) s_b <= rxd_i;
            if (decide) begin
                idx <= idx + 1'b1;
                if (idx == '0) begin
                    if (vote) active <= 1'b0;
                end else if (is_last) begin
                    active <= 1'b0;
                end else if (idx <= IDX_LAST_DATA) begin
                    shreg <= {vote, shreg[DATA_W-1:1]};
                end else begin
                    b9_q <= vote;
                end
            end
        end
    end

    // Receive buffer and flag: written only by an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            bit9_o <= 1'b0;
            flag_o <= 1'b0;
        end else if (accept) begin
            data_o <= shreg;
            bit9_o <= frame_nine;
            flag_o <= 1'b1;
        end else if (flag_clr_i) begin
            flag_o <= 1'b0;
        end
    end

    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> $rose(flag_o));
    assert_stop_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_o) && $past(!nine && chk_i)) |-> bit9_o);
    assert_addr_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_o) && $past(nine && chk_i)) |-> bit9_o);
    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !en_i) |=> !active);
endmodule

// File: rtl/addr_filter_uart.sv
// Top of the asynchronous serial port: synchronises the receive line,
// selects the oversampling tick and joins the transmitter and receiver.
// Assumes software keeps mode and rate bits stable during a frame.
module addr_filter_uart
    import addr_filter_uart_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int FIX_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              rx_en,
    input  logic              chk_en,
    input  logic              dbl_rate,
    input  logic              baud_tick,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_bit9,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    input  logic              rxd,
    output logic              txd,
    output logic              tx_flag,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_flag
);
    logic [1:0] rxd_sync;
    logic       tick;

    // Two-stage synchroniser on the asynchronous receive line.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end

    afu_tick_gen #(.OVS(OVS), .FIX_DIV(FIX_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_sel), .dbl_i(dbl_rate),
        .ext_tick_i(baud_tick), .tick_o(tick)
    );

    afu_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_sel), .tick_i(tick),
        .wr_i(tx_wr), .data_i(tx_data), .bit9_i(tx_bit9),
        .flag_clr_i(tx_flag_clr), .txd_o(txd), .flag_o(tx_flag)
    );

    afu_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_sel), .en_i(rx_en),
        .chk_i(chk_en), .tick_i(tick), .rxd_i(rxd_sync[1]),
        .flag_clr_i(rx_flag_clr), .data_o(rx_data), .bit9_o(rx_bit9),
        .flag_o(rx_flag)
    );

    assert_idle_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (txd && (mode_sel == MODE_SHIFT || mode_sel == MODE_RSVD)) |=> txd);
endmodule

// File: tb/addr_filter_uart_bench.sv
module addr_filter_uart_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       rx_en = 1'b1, chk_en = 1'b0, dbl_rate = 1'b0, baud_tick = 1'b0;
    logic       tx_wr = 1'b0, tx_bit9 = 1'b0, tx_flag_clr = 1'b0, rx_flag_clr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rxd = 1'b1;
    logic       txd, tx_flag, rx_bit9, rx_flag;
    logic [7:0] rx_data;

    int checks = 0, errors = 0;
    int tick_cnt = 0;
    logic done = 1'b0;
    logic [7:0] exp_data = 8'h00;
    logic       exp_b9 = 1'b0;

    always #2 clk = ~clk;

    addr_filter_uart u_addr_filter_uart (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx_en(rx_en),
        .chk_en(chk_en), .dbl_rate(dbl_rate), .baud_tick(baud_tick),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9),
        .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr), .rxd(rxd),
        .txd(txd), .tx_flag(tx_flag), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_flag(rx_flag)
    );

    // External oversampling tick: one pulse every third clock.
    always @(negedge clk) begin
        tick_cnt  <= (tick_cnt == 2) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == 2);
    end

    // Fields: [14:13] mode, [12] chk, [11] dbl, [10] ninth, [9] stop, [8:1] data, [0] accept
    localparam logic [14:0] VEC [0:10] = '{
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h66, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 8'h99, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'hF0, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, 1'b1},
        {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'hE7, 1'b1},
        {2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 8'h18, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [10:0] bits, input int n, input int per);
        for (int i = 0; i < n; i++) begin
            rxd = bits[i];
            clocks(per);
        end
        rxd = 1'b1;
        clocks(per);
    endtask

    task automatic clear_rx;
        rx_flag_clr = 1'b1; clocks(1); rx_flag_clr = 1'b0; clocks(1);
    endtask

    task automatic clear_tx;
        tx_flag_clr = 1'b1; clocks(1); tx_flag_clr = 1'b0; clocks(1);
    endtask

    task automatic write_tx(input logic [7:0] d, input logic b9);
        tx_data = d; tx_bit9 = b9; tx_wr = 1'b1; clocks(1); tx_wr = 1'b0;
    endtask

    task automatic tx_expect(input string tag, input logic [10:0] bits, input int n, input int per);
        int waitc = 0;
        while (txd !== 1'b0 && waitc < 1000) begin clocks(1); waitc++; end
        clocks(per / 2);
        for (int i = 0; i < n; i++) begin
            check(tag, txd, bits[i]);
            check("R4 tx_flag timing", tx_flag, (i == n - 1));
            if (i < n - 1) clocks(per);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clocks(4);
        // R1: reset state
        check("R1 txd", txd, 1'b1);
        check("R1 tx_flag", tx_flag, 1'b0);
        check("R1 rx_flag", rx_flag, 1'b0);
        check("R1 rx_data", rx_data, 8'h00);
        check("R1 rx_bit9", rx_bit9, 1'b0);
        rst_n = 1'b1;
        clocks(4);

        // Receive table walk: R5, R7, R8, R11
        for (int i = 0; i < 11; i++) begin
            logic [14:0] v;
            logic [10:0] bits;
            int n, per;
            string tag;
            v = VEC[i];
            mode_sel = v[14:13]; chk_en = v[12]; dbl_rate = v[11];
            if (v[14:13] == 2'b01) begin
                bits = {1'b1, v[9], v[8:1], 1'b0}; n = 10; per = 48;
                tag = (v[12] || !v[9]) ? "R7" : "R5";
            end else begin
                bits = {v[9], v[10], v[8:1], 1'b0}; n = 11; per = v[11] ? 32 : 64;
                tag = v[11] ? "R11" : "R8";
            end
            clocks(8);
            clear_rx();
            send_frame(bits, n, per);
            if (v[0]) begin
                exp_data = v[8:1];
                exp_b9   = (v[14:13] == 2'b01) ? v[9] : v[10];
            end
            check({tag, " rx_flag"}, rx_flag, v[0]);
            check({tag, " rx_data"}, rx_data, exp_data);
            check({tag, " rx_bit9"}, rx_bit9, exp_b9);
        end

        // R6: frame arriving while flag set is discarded
        mode_sel = 2'b01; chk_en = 1'b0; dbl_rate = 1'b0;
        clocks(8); clear_rx();
        send_frame({1'b1, 1'b1, 8'h42, 1'b0}, 10, 48);
        check("R6 first accepted", rx_data, 8'h42);
        send_frame({1'b1, 1'b1, 8'hBD, 1'b0}, 10, 48);
        check("R6 flag held", rx_flag, 1'b1);
        check("R6 data kept", rx_data, 8'h42);

        // R10: receiver disabled, and inactive modes
        clear_rx();
        rx_en = 1'b0;
        send_frame({1'b1, 1'b1, 8'h77, 1'b0}, 10, 48);
        check("R10 rx_en off flag", rx_flag, 1'b0);
        check("R10 rx_en off data", rx_data, 8'h42);
        rx_en = 1'b1; mode_sel = 2'b00; clocks(4);
        send_frame({1'b1, 1'b1, 8'h11, 1'b0}, 10, 48);
        check("R10 mode 00 flag", rx_flag, 1'b0);
        mode_sel = 2'b11; clocks(4);
        send_frame({1'b1, 1'b1, 8'h22, 1'b0}, 10, 48);
        check("R10 mode 11 flag", rx_flag, 1'b0);

        // R9: short low glitch is rejected as a start bit
        mode_sel = 2'b10; dbl_rate = 1'b0; chk_en = 1'b0; clocks(8);
        rxd = 1'b0; clocks(12); rxd = 1'b1; clocks(128);
        check("R9 glitch rejected", rx_flag, 1'b0);
        send_frame({1'b1, 1'b0, 8'h6C, 1'b0}, 11, 64);
        check("R9 recover flag", rx_flag, 1'b1);
        check("R9 recover data", rx_data, 8'h6C);

        // R2: eight-bit transmit
        mode_sel = 2'b01; clocks(8); clear_tx();
        write_tx(8'h4B, 1'b0);
        tx_expect("R2 txd bit", {1'b1, 1'b1, 8'h4B, 1'b0}, 10, 48);
        clocks(60);

        // R3: nine-bit transmit, normal then doubled
        mode_sel = 2'b10; dbl_rate = 1'b0; clocks(8); clear_tx();
        write_tx(8'hD2, 1'b1);
        tx_expect("R3 txd bit", {1'b1, 1'b1, 8'hD2, 1'b0}, 11, 64);
        clocks(80);
        dbl_rate = 1'b1; clocks(8); clear_tx();
        write_tx(8'h35, 1'b0);
        tx_expect("R3 doubled txd bit", {1'b1, 1'b0, 8'h35, 1'b0}, 11, 32);
        clocks(40);

        // R4: write while busy ignored
        dbl_rate = 1'b0; clocks(8); clear_tx();
        write_tx(8'h5E, 1'b1);
        clocks(3);
        write_tx(8'h00, 1'b0);
        tx_expect("R4 busy write", {1'b1, 1'b1, 8'h5E, 1'b0}, 11, 64);
        clocks(64);
        check("R4 no second frame", txd, 1'b1);
        clocks(64);
        check("R4 line idle", txd, 1'b1);

        // R4: writes in inactive modes ignored
        mode_sel = 2'b00; clocks(4); clear_tx();
        write_tx(8'h00, 1'b0);
        clocks(100);
        check("R4 mode 00 txd", txd, 1'b1);
        check("R4 mode 00 flag", tx_flag, 1'b0);
        mode_sel = 2'b11; clocks(4);
        write_tx(8'h00, 1'b0);
        clocks(100);
        check("R4 mode 11 txd", txd, 1'b1);
        check("R4 mode 11 flag", tx_flag, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule